// File: doc/BRIEF.md
# Multi-Bank Two-Dimensional Address Mapper

This block turns one scan-window step into linear addresses for a set of 2^K independent memory banks. A step carries the window handle position (hx, hy) and one lookup slot per bank. Slot i stands for relative window row i and holds an enable and an x offset. Relative row i touches data row hy+i. Rows are spread across banks so that row y lives in bank y mod 2^K. Any 2^K adjacent window rows therefore fall in distinct banks and can all be served in one cycle.

The slot outputs are rotated onto the physical banks using the low K bits of hy. Inside a bank, rows are stored one after another. Each row is only as wide as the configured map width (`cfg_xbits`), so no gaps are left between rows. An x coordinate that does not fit the configured width drops that bank's access and raises its error bit.

Requests enter on a valid/ready stream and leave one cycle later on a valid/ready stream, through a single register stage. A new step is accepted whenever the output register is empty or is being drained in that same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` stays low. `cfg_xbits` is a plain control input and is sampled when a step is accepted.

Top module: `mb2d_addr_mapper`

## Requirements
- R1: Slot i is delivered to bank (hy + i) mod 2^K, so row y is always served by bank y mod 2^K; with K=2 and hy=3, slot 0 goes to bank 3 and slot 1 to bank 0.
- R2: For an enabled, in-range slot i, with y = (hy + i) mod 2^16 and x = (hx + dx_i) mod 2^16, the bank's address equals ((y >> K) << W) | x, where W is the effective map width.
- R3: The effective map width W is `cfg_xbits` when it is 16 or less, and 16 for any larger value; at W=16 no x value is out of range.
- R4: When x >> W is non-zero, that bank's enable is 0 and its error bit is 1; x = 2^W - 1 is in range and x = 2^W is out of range.
- R5: A bank whose slot is disabled shows enable 0 and error 0.
- R6: A step accepted at a clock edge appears on the outputs with `out_valid` high directly after that edge; if the output is drained with no new input, `out_valid` falls.
- R7: `in_ready` equals `!out_valid || out_ready`; while `out_valid` is high and `out_ready` is low, all output fields stay unchanged.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xbits | input | 5 | Map width in x bits (values above 16 act as 16) |
| in_valid | input | 1 | Step valid |
| in_ready | output | 1 | Step accepted when high with in_valid |
| in_hx | input | 16 | Handle x coordinate |
| in_hy | input | 16 | Handle y coordinate |
| in_slot_en | input | NB | Per-slot enable, bit i for relative row i |
| in_slot_dx | input | NB*16 | Per-slot x offset, slot i at bits [16i+15:16i] |
| out_valid | output | 1 | Bank outputs valid |
| out_ready | input | 1 | Consumer takes the outputs |
| out_bank_en | output | NB | Per-bank access enable, bit b for bank b |
| out_bank_err | output | NB | Per-bank out-of-range flag |
| out_bank_addr | output | NB*AW | Per-bank linear address, bank b at bits [AW*b+AW-1:AW*b], AW = 32-K |

## Verification
Every bank result is due exactly one clock edge after its step is accepted. The bench therefore drives a step at a falling edge and compares enables, error bits and addresses at the next falling edge. `in_ready` is checked combinationally in the same half cycle in which the stimulus is applied. Under back-pressure, the outputs are compared again one full cycle later against the earlier step's expected values. Only after `out_ready` returns does the bench expect the new step, one edge later.

// File: rtl/mb2d_pkg.sv
package mb2d_pkg;
  localparam int COORD_W = 16;
  localparam int XB_W    = 5;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [XB_W-1:0]    xbits_t;

  // Widths above the coordinate size behave as the full coordinate size.
  function automatic xbits_t clamp_xbits(input xbits_t v);
    return (v > xbits_t'(COORD_W)) ? xbits_t'(COORD_W) : v;
  endfunction
endpackage

// File: rtl/mb2d_steer.sv
module mb2d_steer
  import mb2d_pkg::*;
#(
  parameter int K  = 2,
  parameter int NB = 1 << K,
  parameter int SW = (K == 0) ? 1 : K
) (
  input  coord_t                 hy,
  input  logic [NB-1:0]          slot_en,
  input  logic [NB*COORD_W-1:0]  slot_dx,
  output logic [NB*SW-1:0]       bank_rel,
  output logic [NB-1:0]          bank_en,
  output logic [NB*COORD_W-1:0]  bank_dx
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [SW-1:0] sel;
    if (K == 0) begin : g_single
      assign sel = '0;
    end else begin : g_rot
      // Relative row landing on bank b: (b - hy) mod 2^K.
      assign sel = SW'(b) - hy[SW-1:0];
    end
    assign bank_rel[b*SW +: SW]           = sel;
    assign bank_en[b]                     = slot_en[sel];
    assign bank_dx[b*COORD_W +: COORD_W]  = slot_dx[sel*COORD_W +: COORD_W];
  end
endmodule

// File: rtl/mb2d_lane.sv
module mb2d_lane
  import mb2d_pkg::*;
#(
  parameter int K  = 2,
  parameter int SW = (K == 0) ? 1 : K,
  parameter int AW = 2*COORD_W - K
) (
  input  coord_t         hx,
  input  coord_t         hy,
  input  logic [SW-1:0]  rel,
  input  logic           en,
  input  coord_t         dx,
  input  xbits_t         xbits,
  output logic           acc,
  output logic           err,
  output logic [AW-1:0]  addr
);
  coord_t          y, x;
  logic            fits;
  logic [AW-1:0]   row;

  always_comb begin
    y    = hy + ((K == 0) ? '0 : coord_t'(rel));
    x    = hx + dx;
    fits = (x >> xbits) == '0;
    row  = AW'(y >> K);
    addr = (row << xbits) | AW'(x);
    acc  = en & fits;
    err  = en & ~fits;
  end
endmodule

// File: rtl/mb2d_addr_mapper.sv
module mb2d_addr_mapper
  import mb2d_pkg::*;
#(
  parameter int K  = 2,
  parameter int NB = 1 << K,
  parameter int AW = 2*COORD_W - K
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [XB_W-1:0]        cfg_xbits,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [COORD_W-1:0]     in_hx,
  input  logic [COORD_W-1:0]     in_hy,
  input  logic [NB-1:0]          in_slot_en,
  input  logic [NB*COORD_W-1:0]  in_slot_dx,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NB-1:0]          out_bank_en,
  output logic [NB-1:0]          out_bank_err,
  output logic [NB*AW-1:0]       out_bank_addr
);
  localparam int SW = (K == 0) ? 1 : K;

  logic [NB*SW-1:0]       st_rel;
  logic [NB-1:0]          st_en;
  logic [NB*COORD_W-1:0]  st_dx;
  logic [NB-1:0]          nx_en, nx_err;
  logic [NB*AW-1:0]       nx_addr;
  xbits_t                 xb_eff;
  logic                   load;

  assign xb_eff   = clamp_xbits(cfg_xbits);
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  mb2d_steer #(.K(K), .NB(NB), .SW(SW)) u_steer (
    .hy       (in_hy),
    .slot_en  (in_slot_en),
    .slot_dx  (in_slot_dx),
    .bank_rel (st_rel),
    .bank_en  (st_en),
    .bank_dx  (st_dx)
  );

  for (genvar b = 0; b < NB; b++) begin : g_lane
    mb2d_lane #(.K(K), .SW(SW), .AW(AW)) u_lane (
      .hx    (in_hx),
      .hy    (in_hy),
      .rel   (st_rel[b*SW +: SW]),
      .en    (st_en[b]),
      .dx    (st_dx[b*COORD_W +: COORD_W]),
      .xbits (xb_eff),
      .acc   (nx_en[b]),
      .err   (nx_err[b]),
      .addr  (nx_addr[b*AW +: AW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_bank_en   <= '0;
      out_bank_err  <= '0;
      out_bank_addr <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load) begin
        out_bank_en   <= nx_en;
        out_bank_err  <= nx_err;
        out_bank_addr <= nx_addr;
      end
    end
  end
endmodule

// File: rtl/mb2d_addr_mapper_chk.sv
module mb2d_addr_mapper_chk #(
  parameter int NB = 4,
  parameter int AW = 30
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     cfg_xbits,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [NB-1:0]  out_bank_en,
  input logic [NB-1:0]  out_bank_err,
  input logic [NB*AW-1:0] out_bank_addr
);
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bank_addr) && $stable(out_bank_en) && $stable(out_bank_err)); // R7
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7
  AST_EN_ERR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bank_en & out_bank_err) == '0); // R4
  AST_FULL_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cfg_xbits >= 5'd16 |=> out_bank_err == '0); // R3
endmodule

bind mb2d_addr_mapper mb2d_addr_mapper_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_xbits     (cfg_xbits),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_bank_en   (out_bank_en),
  .out_bank_err  (out_bank_err),
  .out_bank_addr (out_bank_addr)
);

// File: tb/mb2d_addr_mapper_tb.sv
module mb2d_addr_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K  = 2;
  localparam int NB = 1 << K;
  localparam int CW = 16;
  localparam int AW = 2*CW - K;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        cfg_xbits = 5'd8;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [CW-1:0]     in_hx = '0;
  logic [CW-1:0]     in_hy = '0;
  logic [NB-1:0]     in_slot_en = '0;
  logic [NB*CW-1:0]  in_slot_dx = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [NB-1:0]     out_bank_en;
  logic [NB-1:0]     out_bank_err;
  logic [NB*AW-1:0]  out_bank_addr;

  logic [NB-1:0]     exp_en, exp_err;
  logic [NB*AW-1:0]  exp_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mb2d_addr_mapper #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_xbits(cfg_xbits),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_hx(in_hx), .in_hy(in_hy), .in_slot_en(in_slot_en), .in_slot_dx(in_slot_dx),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bank_en(out_bank_en), .out_bank_err(out_bank_err), .out_bank_addr(out_bank_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected bank results from the requirements (R1..R5).
  task automatic model();
    int w;
    w = (cfg_xbits > 16) ? 16 : int'(cfg_xbits);   // R3
    exp_en = '0; exp_err = '0; exp_addr = '0;
    for (int i = 0; i < NB; i++) begin
      logic [CW-1:0] y, x;
      int b;
      y = in_hy + CW'(i);
      x = in_hx + in_slot_dx[i*CW +: CW];
      b = int'(y) % NB;                               // R1
      if (in_slot_en[i]) begin                        // R5
        if ((32'(x) >> w) != 0) exp_err[b] = 1'b1;    // R4
        else begin
          exp_en[b] = 1'b1;
          exp_addr[b*AW +: AW] = AW'((64'(y) >> K) << w) | AW'(x); // R2
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    check(out_valid === 1'b1, {tag, " R6 out_valid"}, 64'(out_valid), 1);
    for (int b = 0; b < NB; b++) begin
      check(out_bank_en[b] === exp_en[b], {tag, " R1/R5 en"}, 64'(out_bank_en[b]), 64'(exp_en[b]));
      check(out_bank_err[b] === exp_err[b], {tag, " R4 err"}, 64'(out_bank_err[b]), 64'(exp_err[b]));
      if (exp_en[b])
        check(out_bank_addr[b*AW +: AW] === exp_addr[b*AW +: AW], {tag, " R2 addr"},
              64'(out_bank_addr[b*AW +: AW]), 64'(exp_addr[b*AW +: AW]));
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic txn(input string tag, input logic [4:0] xb, input logic [CW-1:0] hx,
                     input logic [CW-1:0] hy, input logic [NB-1:0] en, input logic [NB*CW-1:0] dx);
    cfg_xbits = xb; in_hx = hx; in_hy = hy; in_slot_en = en; in_slot_dx = dx;
    in_valid = 1'b1; out_ready = 1'b1;
    model();
    #1 check(in_ready === 1'b1, {tag, " R7 ready"}, 64'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0, "R8 reset valid", 64'(out_valid), 0);
    check(in_ready === 1'b1, "R8 reset ready", 64'(in_ready), 1);
    @(negedge clk);

    // R1 identity and rotation
    txn("R1 hy0", 5'd8, 16'd5, 16'd0, 4'hF, {16'd3, 16'd2, 16'd1, 16'd0});
    txn("R1 hy3", 5'd8, 16'd5, 16'd3, 4'hF, {16'd3, 16'd2, 16'd1, 16'd0});
    // R2 wrap of y at 16 bits
    txn("R2 ywrap", 5'd16, 16'hFFF0, 16'hFFFE, 4'hF, {16'h0001, 16'h0020, 16'h0000, 16'h000F});
    // R3 clamp above 16 and full width
    txn("R3 clamp", 5'd31, 16'hFFFF, 16'd9, 4'hF, {16'd0, 16'd7, 16'd0, 16'd1});
    txn("R3 w0", 5'd0, 16'd0, 16'd6, 4'hF, {16'd0, 16'd0, 16'd1, 16'd0});
    // R4 edge: 2^W-1 fits, 2^W does not
    txn("R4 edge", 5'd4, 16'd0, 16'd1, 4'hF, {16'd16, 16'd15, 16'd16, 16'd15});
    // R5 disabled slots
    txn("R5 off", 5'd4, 16'd100, 16'd2, 4'b0101, {16'd0, 16'd0, 16'd0, 16'd0});

    // R6 drain: output falls with no new input
    @(negedge clk);
    check(out_valid === 1'b0, "R6 drain", 64'(out_valid), 0);

    // R7 back-pressure
    txn("R7 first", 5'd6, 16'd3, 16'd1, 4'hF, {16'd1, 16'd2, 16'd3, 16'd4});
    out_ready = 1'b0;
    cfg_xbits = 5'd7; in_hx = 16'd40; in_hy = 16'd10; in_slot_en = 4'hB;
    in_slot_dx = {16'd9, 16'd8, 16'd7, 16'd6};
    in_valid = 1'b1;
    #1 check(in_ready === 1'b0, "R7 stalled ready", 64'(in_ready), 0);
    @(negedge clk);
    compare("R7 hold");
    out_ready = 1'b1;
    model();
    #1 check(in_ready === 1'b1, "R7 release ready", 64'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    compare("R7 second");

    // Random mix (R1 R2 R4 R5)
    for (int n = 0; n < 400; n++) begin
      logic [NB*CW-1:0] dx;
      logic [4:0] xb;
      for (int i = 0; i < NB; i++) dx[i*CW +: CW] = CW'($urandom_range(0, 300));
      xb = 5'($urandom_range(0, 20));
      txn("rand R1 R2 R4 R5", xb, CW'($urandom), CW'($urandom), NB'($urandom), dx);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule